// File: doc/BRIEF.md
# Maskable Interrupt Entry and Return Sequencer

This block is the interrupt control unit of a small processor core. Twelve maskable request lines, carrying interrupt IDs 4 through 15, are latched into a pending-flag register. A pending flag is eligible only when three conditions hold together: the global enable bit of the control-status word is set, the master enable bit of the enable register is set, and the flag's own enable bit is set. Among the eligible flags the lowest ID is chosen.

Once a request is accepted, the block stalls instruction fetch. It then waits until the execute pipe is empty, memory operations have finished and any delay-slot instruction has retired. After that it steps through a fixed entry sequence. The ID is stamped into the status word, and the status word is copied to a saved status register. A shadow-save strobe goes out with a one-cycle acknowledge and the ID. The global enable and the taken flag are cleared, and the next-instruction PC is kept as the return pointer. Last, a fetch from the vector table is requested and the fetched word becomes the new PC. A return command restores the status word from the saved copy, pulses a shadow-restore strobe and loads the PC from the return pointer. The pipeline, the decoder and the shadow registers are outside the block; only strobes toward them are provided.

Top module: `irq_entry_ctrl`

## Requirements
- R1: A one-cycle high on `irq_req_i[k]` sets `ifr_o[k]` (interrupt ID k+4) at the next clock edge. The bit stays set until the entry sequence for that ID clears it.
- R2: A request is accepted only when `csr_o[0]` (global enable) is 1, `ier_o[1]` (master enable) is 1 and `ier_o[ID]` is 1. Otherwise `fetch_stall_o` stays low and the flags are kept.
- R3: After reset `csr_o[0]` is 0. It is 0 in the cycle after the acknowledge of every entry.
- R4: `fetch_stall_o` rises before the acknowledge. The acknowledge comes no earlier than two cycles after `pipe_empty_i`, `mem_idle_i` and `slot_done_i` are seen high together while stalled.
- R5: In the acknowledge cycle, `csr_o[11:8]` holds the accepted ID. In the next cycle, `scsr_o` equals the status word with that ID and with the global enable still 1.
- R6: `shadow_save_o` is high in the acknowledge cycle. In the next cycle the accepted flag bit is 0 and `irp_o` equals the `next_pc_i` value sampled in the acknowledge cycle.
- R7: `iack_o` is high for exactly one cycle per entry, with `inum_o` carrying the accepted ID.
- R8: After the acknowledge, `vec_req_o` stays high with `vec_addr_o = vec_base_i + 4*ID` until `vec_ack_i`. In that cycle `pc_load_o` is high with `pc_val_o = vec_data_i`, and the stall drops in the next cycle.
- R9: When the block is idle, `rti_i` makes `shadow_restore_o` and `pc_load_o` high in the same cycle, with `pc_val_o = irp_o`. In the next cycle `csr_o` equals `scsr_o`.
- R10: When several eligible flags are pending, the lowest ID is accepted.
- R11: A request that arrives during an entry stays in `ifr_o`. It is accepted only after the global enable is 1 again.
- R12: After reset `ier_o`, `ifr_o` and `csr_o` are 0, and `fetch_stall_o` and `iack_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req_i | input | 12 | Request lines, bit k is ID k+4 |
| csr_wr_en_i | input | 1 | Software write of the status word |
| csr_wr_data_i | input | 16 | Status word write data |
| ier_wr_en_i | input | 1 | Software write of the enable register |
| ier_wr_data_i | input | 16 | Enable register write data |
| pipe_empty_i | input | 1 | Execute pipe drained |
| mem_idle_i | input | 1 | No load, store, call or return outstanding |
| slot_done_i | input | 1 | No delay-slot instruction pending |
| next_pc_i | input | 32 | PC of the next instruction to run |
| vec_base_i | input | 32 | Vector table base address |
| vec_ack_i | input | 1 | Vector fetch completed |
| vec_data_i | input | 32 | Fetched vector entry |
| rti_i | input | 1 | Return-from-interrupt command |
| csr_o | output | 16 | Status word |
| scsr_o | output | 16 | Saved status word |
| ier_o | output | 16 | Enable register |
| ifr_o | output | 12 | Pending flags |
| irp_o | output | 32 | Return pointer |
| fetch_stall_o | output | 1 | Stop instruction fetch |
| shadow_save_o | output | 1 | Save strobe to shadow registers |
| shadow_restore_o | output | 1 | Restore strobe from shadow registers |
| iack_o | output | 1 | Acknowledge pulse |
| inum_o | output | 4 | Accepted ID |
| vec_req_o | output | 1 | Vector fetch request |
| vec_addr_o | output | 32 | Vector fetch address |
| pc_load_o | output | 1 | Load PC |
| pc_val_o | output | 32 | New PC value |

## Verification
Random pending masks are combined with random enable words and random global and master enable bits. This separates the three-way qualification from the lowest-ID choice, and chained entries after each return show that untaken flags survive. Drain holds of several lengths, each on a different one of the three drain inputs, show that each input alone can delay the acknowledge. Requests injected during the drain wait show that they are latched but not taken until the return. Random vector bases, vector data and return PCs tell the address arithmetic and the PC mux apart from stale values.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int ID_W   = 4;
  localparam int ADDR_W = 32;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_DRAIN = 3'd1,
    S_TAG   = 3'd2,
    S_SAVE  = 3'd3,
    S_VEC   = 3'd4
  } seq_state_t;

  // vector table slot address: one word per ID
  function automatic logic [ADDR_W-1:0] vec_addr_f(input logic [ADDR_W-1:0] base,
                                                    input logic [ID_W-1:0]   id);
    return base + {{(ADDR_W-ID_W-2){1'b0}}, id, 2'b00};
  endfunction
endpackage

// File: rtl/irq_flags.sv
module irq_flags #(
  parameter int N     = 12,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req_i,
  input  logic             clr_en_i,
  input  logic [IDX_W-1:0] clr_idx_i,
  output logic [N-1:0]     flags_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic hit_clr;
    assign hit_clr = clr_en_i && (clr_idx_i == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flags_o[g] <= 1'b0;
      else if (req_i[g])   flags_o[g] <= 1'b1;   // a new request beats a clear
      else if (hit_clr)    flags_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N     = 12,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     pend_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    any_o = |pend_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--)
      if (pend_i[i]) idx_o = IDX_W'(i);
  end

  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> (pend_i[idx_o] && ((pend_i & ((N'(1) << idx_o) - N'(1))) == '0))); // R10
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_ctrl_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_i,
  input  logic [IDX_W-1:0] pick_idx_i,
  input  logic             drained_i,
  input  logic             vec_ack_i,
  output seq_state_t       state_o,
  output logic [IDX_W-1:0] idx_o
);
  seq_state_t nxt;

  always_comb begin
    nxt = state_o;
    case (state_o)
      S_IDLE:  if (take_i)    nxt = S_DRAIN;
      S_DRAIN: if (drained_i) nxt = S_TAG;
      S_TAG:                  nxt = S_SAVE;
      S_SAVE:                 nxt = S_VEC;
      S_VEC:   if (vec_ack_i) nxt = S_IDLE;
      default:                nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_o <= S_IDLE;
      idx_o   <= '0;
    end else begin
      state_o <= nxt;
      if (state_o == S_IDLE && take_i) idx_o <= pick_idx_i;
    end
  end

  AST_DRAIN_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == S_TAG) |-> $past(drained_i)); // R4
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int N_IRQ  = 12,
  parameter int IRQ_LO = 4,
  parameter int CSR_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IRQ-1:0]  irq_req_i,
  input  logic              csr_wr_en_i,
  input  logic [CSR_W-1:0]  csr_wr_data_i,
  input  logic              ier_wr_en_i,
  input  logic [CSR_W-1:0]  ier_wr_data_i,
  input  logic              pipe_empty_i,
  input  logic              mem_idle_i,
  input  logic              slot_done_i,
  input  logic [ADDR_W-1:0] next_pc_i,
  input  logic [ADDR_W-1:0] vec_base_i,
  input  logic              vec_ack_i,
  input  logic [ADDR_W-1:0] vec_data_i,
  input  logic              rti_i,
  output logic [CSR_W-1:0]  csr_o,
  output logic [CSR_W-1:0]  scsr_o,
  output logic [CSR_W-1:0]  ier_o,
  output logic [N_IRQ-1:0]  ifr_o,
  output logic [ADDR_W-1:0] irp_o,
  output logic              fetch_stall_o,
  output logic              shadow_save_o,
  output logic              shadow_restore_o,
  output logic              iack_o,
  output logic [ID_W-1:0]   inum_o,
  output logic              vec_req_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic              pc_load_o,
  output logic [ADDR_W-1:0] pc_val_o
);
  localparam int IDX_W   = $clog2(N_IRQ);
  localparam int GIE_BIT = 0;
  localparam int MST_BIT = 1;
  localparam int INUM_LO = 8;

  seq_state_t       st;
  logic [IDX_W-1:0] pick_idx, cur_idx;
  logic             any_elig, take, rti_go, drained;
  logic [N_IRQ-1:0] elig;
  logic [ID_W-1:0]  cur_id;
  logic             ev_tag, ev_save, ev_vec_done;

  assign elig    = ifr_o & ier_o[IRQ_LO +: N_IRQ];
  assign drained = pipe_empty_i && mem_idle_i && slot_done_i;
  assign rti_go  = (st == S_IDLE) && rti_i;
  assign take    = (st == S_IDLE) && !rti_i && csr_o[GIE_BIT] && ier_o[MST_BIT] && any_elig;
  assign cur_id  = ID_W'(cur_idx) + ID_W'(IRQ_LO);
  assign ev_tag      = (st == S_TAG);
  assign ev_save     = (st == S_SAVE);
  assign ev_vec_done = (st == S_VEC) && vec_ack_i;

  irq_flags #(.N(N_IRQ), .IDX_W(IDX_W)) i_flags (
    .clk(clk), .rst_n(rst_n), .req_i(irq_req_i),
    .clr_en_i(ev_save), .clr_idx_i(cur_idx), .flags_o(ifr_o));

  irq_pick #(.N(N_IRQ), .IDX_W(IDX_W)) i_pick (
    .clk(clk), .rst_n(rst_n), .pend_i(elig), .any_o(any_elig), .idx_o(pick_idx));

  irq_seq #(.IDX_W(IDX_W)) i_seq (
    .clk(clk), .rst_n(rst_n), .take_i(take), .pick_idx_i(pick_idx),
    .drained_i(drained), .vec_ack_i(vec_ack_i), .state_o(st), .idx_o(cur_idx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csr_o  <= '0;
      scsr_o <= '0;
      ier_o  <= '0;
      irp_o  <= '0;
    end else begin
      if (ev_tag)          csr_o[INUM_LO +: ID_W] <= cur_id;
      else if (ev_save)    csr_o[GIE_BIT] <= 1'b0;
      else if (rti_go)     csr_o <= scsr_o;
      else if (csr_wr_en_i) csr_o <= csr_wr_data_i;
      if (ev_save) begin
        scsr_o <= csr_o;
        irp_o  <= next_pc_i;
      end
      if (ier_wr_en_i) ier_o <= ier_wr_data_i;
    end
  end

  assign fetch_stall_o    = (st != S_IDLE);
  assign shadow_save_o    = ev_save;
  assign shadow_restore_o = rti_go;
  assign iack_o           = ev_save;
  assign inum_o           = cur_id;
  assign vec_req_o        = (st == S_VEC);
  assign vec_addr_o       = vec_addr_f(vec_base_i, cur_id);
  assign pc_load_o        = rti_go || ev_vec_done;
  assign pc_val_o         = rti_go ? irp_o : vec_data_i;

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    iack_o |=> !iack_o); // R7
  AST_GIE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    iack_o |=> !csr_o[GIE_BIT]); // R3
  AST_ID_STAMPED: assert property (@(posedge clk) disable iff (!rst_n)
    iack_o |-> (csr_o[INUM_LO +: ID_W] == inum_o)); // R5
  AST_STALL_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iack_o) |-> $past(fetch_stall_o, 2)); // R4
  AST_RESTORE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    shadow_restore_o |-> (!fetch_stall_o && pc_val_o == irp_o)); // R9
  AST_SAVE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    iack_o |=> (scsr_o[INUM_LO +: ID_W] == $past(inum_o))); // R5
endmodule

// File: tb/test_irq_entry_ctrl.sv
module test_irq_entry_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] irq_req_i = '0;
  logic        csr_wr_en_i = 1'b0;
  logic [15:0] csr_wr_data_i = '0;
  logic        ier_wr_en_i = 1'b0;
  logic [15:0] ier_wr_data_i = '0;
  logic        pipe_empty_i = 1'b1, mem_idle_i = 1'b1, slot_done_i = 1'b1;
  logic [31:0] next_pc_i = '0, vec_base_i = '0, vec_data_i = '0;
  logic        vec_ack_i = 1'b0, rti_i = 1'b0;
  logic [15:0] csr_o, scsr_o, ier_o;
  logic [11:0] ifr_o;
  logic [31:0] irp_o, vec_addr_o, pc_val_o;
  logic        fetch_stall_o, shadow_save_o, shadow_restore_o, iack_o, vec_req_o, pc_load_o;
  logic [3:0]  inum_o;

  int total = 0, bad = 0;
  logic [15:0] csr_m = '0, scsr_m = '0, ier_m = '0;
  logic [11:0] ifr_m = '0;
  logic [31:0] irp_m = '0;

  always #2.5 clk = ~clk;

  irq_entry_ctrl i_irq_entry_ctrl (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit eligible();
    return csr_m[0] && ier_m[1] && ((ifr_m & ier_m[15:4]) != 0);
  endfunction

  function automatic logic [3:0] lowest_id();
    for (int i = 0; i < 12; i++)
      if (ifr_m[i] && ier_m[4+i]) return 4'(i + 4);
    return 4'd0;
  endfunction

  function automatic logic [31:0] slot_addr(input logic [31:0] base, input logic [3:0] id);
    return base + 32'(id) * 32'd4;
  endfunction

  task automatic wr_csr(input logic [15:0] d);
    @(negedge clk); csr_wr_en_i = 1'b1; csr_wr_data_i = d;
    @(negedge clk); csr_wr_en_i = 1'b0; csr_m = d;
  endtask

  task automatic wr_ier(input logic [15:0] d);
    @(negedge clk); ier_wr_en_i = 1'b1; ier_wr_data_i = d;
    @(negedge clk); ier_wr_en_i = 1'b0; ier_m = d;
  endtask

  task automatic pulse_req(input logic [11:0] m);
    @(negedge clk); irq_req_i = m;
    @(negedge clk); irq_req_i = '0; ifr_m |= m;
    chk("R1 flag latch", 32'(ifr_o), 32'(ifr_m));
  endtask

  task automatic run_entry(input logic [3:0] exp_id, input int delay, input logic [11:0] late);
    int n = 0;
    int which = int'($urandom_range(0, 2));
    logic [31:0] pc = $urandom;
    while (!fetch_stall_o && n < 6) begin @(negedge clk); n++; end
    chk("R4 stall raised", 32'(fetch_stall_o), 32'd1);
    next_pc_i = pc;
    irq_req_i = late;
    if (delay > 0) begin
      if (which == 0) pipe_empty_i = 1'b0;
      else if (which == 1) mem_idle_i = 1'b0;
      else slot_done_i = 1'b0;
    end
    for (int i = 0; i < delay; i++) begin
      @(negedge clk); irq_req_i = '0;
      chk("R4 no ack before drain", 32'(iack_o), 32'd0);
    end
    pipe_empty_i = 1'b1; mem_idle_i = 1'b1; slot_done_i = 1'b1;
    ifr_m |= late;
    @(negedge clk); irq_req_i = '0;
    chk("R4 no ack one cycle after drain", 32'(iack_o), 32'd0);
    @(negedge clk);
    chk("R7 ack high", 32'(iack_o), 32'd1);
    chk("R7 ack id", 32'(inum_o), 32'(exp_id));
    chk("R10 lowest id", 32'(inum_o), 32'(exp_id));
    chk("R6 save strobe", 32'(shadow_save_o), 32'd1);
    chk("R5 id in status", 32'(csr_o[11:8]), 32'(exp_id));
    scsr_m = {csr_m[15:12], exp_id, csr_m[7:1], 1'b1};
    csr_m  = {csr_m[15:12], exp_id, csr_m[7:1], 1'b0};
    ifr_m[exp_id - 4'd4] = 1'b0;
    irp_m = pc;
    @(negedge clk);
    chk("R7 ack single cycle", 32'(iack_o), 32'd0);
    chk("R3 global enable cleared", 32'(csr_o[0]), 32'd0);
    chk("R5 saved status", 32'(scsr_o), 32'(scsr_m));
    chk("R6 return pointer", irp_o, irp_m);
    chk("R6 flag cleared", 32'(ifr_o), 32'(ifr_m));
    chk("R11 late request kept", 32'(ifr_o & late), 32'(late & ifr_m));
    chk("R8 vector request", 32'(vec_req_o), 32'd1);
    chk("R8 vector address", vec_addr_o, slot_addr(vec_base_i, exp_id));
    repeat ($urandom_range(0, 2)) begin
      @(negedge clk);
      chk("R8 request held", 32'(vec_req_o), 32'd1);
      chk("R11 no new ack", 32'(iack_o), 32'd0);
    end
    vec_ack_i = 1'b1; vec_data_i = $urandom;
    #1;
    chk("R8 pc load", 32'(pc_load_o), 32'd1);
    chk("R8 pc value", pc_val_o, vec_data_i);
    @(negedge clk); vec_ack_i = 1'b0;
    chk("R8 stall released", 32'(fetch_stall_o), 32'd0);
  endtask

  task automatic run_rti();
    @(negedge clk); rti_i = 1'b1;
    #1;
    chk("R9 restore strobe", 32'(shadow_restore_o), 32'd1);
    chk("R9 pc load", 32'(pc_load_o), 32'd1);
    chk("R9 pc value", pc_val_o, irp_m);
    @(negedge clk); rti_i = 1'b0;
    csr_m = scsr_m;
    chk("R9 status restored", 32'(csr_o), 32'(csr_m));
  endtask

  task automatic serve_all();
    while (eligible()) begin
      run_entry(lowest_id(), int'($urandom_range(0, 5)),
                ($urandom_range(0, 1) == 1) ? 12'($urandom) : 12'd0);
      run_rti();
    end
    repeat (3) begin
      @(negedge clk);
      chk("R2 nothing taken", 32'(fetch_stall_o), 32'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog R4 actual=timeout expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7731));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 status reset", 32'(csr_o), 32'd0);
    chk("R3 global enable reset", 32'(csr_o[0]), 32'd0);
    chk("R12 enable reset", 32'(ier_o), 32'd0);
    chk("R12 flags reset", 32'(ifr_o), 32'd0);
    chk("R12 no stall", 32'(fetch_stall_o), 32'd0);
    chk("R12 no ack", 32'(iack_o), 32'd0);

    // directed: master enable off blocks everything
    vec_base_i = 32'h0000_8000;
    wr_ier(16'hFFF0);
    pulse_req(12'h801);
    wr_csr(16'h0001);
    repeat (4) begin
      @(negedge clk);
      chk("R2 master enable off", 32'(fetch_stall_o), 32'd0);
    end
    chk("R2 flags kept", 32'(ifr_o), 32'h801);
    // directed: per-line enable off for ID 4, so ID 15 wins
    wr_csr(16'h0000);
    wr_ier(16'hFFE2);
    wr_csr(16'h0001);
    serve_all();
    chk("R2 disabled flag kept", 32'(ifr_o), 32'(ifr_m));
    // directed: IDs 4 and 15 both enabled, lowest wins
    wr_csr(16'h0000);
    wr_ier(16'hFFF2);
    pulse_req(12'h800);
    wr_csr(16'h0001);
    chk("R10 expect id 4", 32'(lowest_id()), 32'd4);
    serve_all();

    for (int it = 0; it < 60; it++) begin
      logic [15:0] e;
      vec_base_i = $urandom & 32'hFFFF_FFFC;
      wr_csr(16'($urandom) & 16'hFFFE);
      e = 16'($urandom);
      e[1] = ($urandom_range(0, 3) != 0);
      wr_ier(e);
      pulse_req(12'($urandom) & 12'($urandom));
      wr_csr((16'($urandom) & 16'hFFFE) | 16'(($urandom_range(0, 3) != 0) ? 1 : 0));
      serve_all();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule